// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Occupancy Flags

This block buffers 18-bit words between two unrelated, free-running clocks. A producer on the write clock offers words with a pair of write enables of opposite polarity. It is held off by an input-ready flag that the write side computes. A consumer on the read clock sees the oldest word already sitting in an output register, marked by an output-ready flag. The consumer takes that word by pulling its read enable and both output enables low. The first word to arrive drops into the output register on its own, without any read request.

Read and write positions cross between the clock domains as Gray codes through two-stage synchronizers. Both ready flags are therefore conservative: they never report data or space that does not exist. On the write side, two more flags describe how full the storage behind the output register is. One is a half-full flag. The other is a combined almost-full/almost-empty flag, whose threshold is captured while the block is held in reset.

The reset input is active low and may be asserted asynchronously. Each clock domain releases it through its own two-stage synchronizer. It must be held across at least four rising edges of each clock.

Top module: `dual_clk_ft_fifo`

## Requirements
- R1: Words leave on `rd_data` in exactly the order they were accepted, with none lost or repeated. The storage holds 64 words of 18 bits, not counting the output register.
- R2: A word is accepted on a rising `wr_clk` edge only when `wr_en_hi`=1, `wr_en_lo_n`=0 and `in_ready`=1. Any other combination writes nothing.
- R3: The word on `rd_data` is consumed on a rising `rd_clk` edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_ready`=1. Otherwise `rd_data` and `out_ready` hold their values.
- R4: While `out_ready` is 0, a stored word moves into the output register and raises `out_ready`, whatever the levels of the three read-side enables.
- R5: With no reads, exactly 65 words are accepted after reset: 64 in storage plus 1 in the output register. `in_ready` is then 0, and further write attempts change nothing.
- R6: While reset is held, `in_ready`, `out_ready` and `half_full` are 0 and `almost_flag` is 1.
- R7: `half_full` is 1 exactly when the stored count (words behind the output register) is 33 or more. It is updated at the write-clock edge that changes the count.
- R8: `almost_flag` is 1 exactly when the stored count is at most T or at least 64−T. T defaults to 8.
- R9: On every `wr_clk` edge during reset, T is loaded from `thr_in` if `thr_load`=1, and set back to 8 if `thr_load`=0.
- R10: Once the last stored word has been consumed, `out_ready` falls to 0 and stays 0 until another word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_load | input | 1 | Selects `thr_in` as the threshold during reset |
| thr_in | input | 6 | Almost-full/almost-empty threshold value |
| wr_data | input | 18 | Word to write |
| wr_en_hi | input | 1 | Active-high write enable |
| wr_en_lo_n | input | 1 | Active-low write enable |
| in_ready | output | 1 | Room for a write (write clock) |
| rd_en_n | input | 1 | Active-low read enable |
| oe_a_n | input | 1 | Active-low output enable A, also gates reads |
| oe_b_n | input | 1 | Active-low output enable B, also gates reads |
| rd_data | output | 18 | Output register |
| out_ready | output | 1 | `rd_data` holds a valid word (read clock) |
| half_full | output | 1 | Stored count at least 33 (write clock) |
| almost_flag | output | 1 | Stored count near empty or near full (write clock) |

## Verification
`in_ready`, `half_full` and `almost_flag` change at the same write edge that commits a word. The bench therefore samples them on the falling write edge right after each write, with reads stopped so that the synchronized read position is constant. A newly written word reaches `out_ready` only after two read edges of synchronization plus the loading edge. Fall-through and enable-gating checks wait ten read cycles before sampling. The scoreboard compares `rd_data` on the falling read edge before each consuming edge, so the word seen is the one that the edge removes.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
// fifo_pkg: default geometry and threshold shared by the FIFO modules.
// Assumes nothing; only constants live here.
package fifo_pkg;
    parameter int DEF_DW  = 18;  // word width
    parameter int DEF_AW  = 6;   // log2 of storage depth
    parameter int DEF_THR = 8;   // default almost-full/almost-empty distance
endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
// fifo_sync: two-stage synchronizer for a W-bit bus into clk.
// Assumes the bus changes at most one bit at a time (Gray code) or is a
// single level; cleared asynchronously by rst_n. With d tied high it
// serves as a reset synchronizer (async assert, sync release).
module fifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two flops in series; the first may go metastable, the second settles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/fifo_mem.sv
`timescale 1ns/1ps
// fifo_mem: 2**AW x DW storage, written on the write clock, read
// combinationally at raddr. Assumes the reader only addresses entries whose
// write has already been published through the synchronized pointer.
module fifo_mem #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] store [ENTRIES];

    // Write port: one word per enabled write-clock edge.
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // Read port: asynchronous, stable because the entry is already committed.
    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/1ps
// fifo_wr_ctrl: write pointer, input-ready, half-full and the
// almost-full/almost-empty flag, all in the write-clock domain.
// Assumes rgray_s is the read pointer (Gray) already synchronized here;
// the count it yields can only overstate occupancy, so in_ready is safe.
// The threshold is captured on every edge while the side is in reset.
module fifo_wr_ctrl #(
    parameter int AW      = 6,
    parameter int THR_DEF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW:0]   rgray_s,
    input  logic          thr_load,
    input  logic [AW-1:0] thr_in,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          in_ready,
    output logic          half_full,
    output logic          almost_flag
);
    localparam logic [AW:0] DEPTH     = (AW+1)'(1 << AW);
    localparam logic [AW:0] HALF_MARK = (AW+1)'((1 << AW) / 2 + 1);

    logic [AW:0]   wbin, wbin_nx, rbin_s, used_nx, hi_mark;
    logic [AW-1:0] thr_q;
    logic          hold_q;

    // Convert the synchronized Gray read pointer back to binary.
    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    assign push    = wr_req & in_ready;
    assign wbin_nx = wbin + {{AW{1'b0}}, push};
    assign used_nx = wbin_nx - rbin_s;
    assign hi_mark = DEPTH - {1'b0, thr_q};
    assign waddr   = wbin[AW-1:0];

    // Marks the edges on which the side is still held in reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b1;
        else        hold_q <= 1'b0;
    end

    // Threshold register: loaded or defaulted only while held in reset.
    always_ff @(posedge clk) begin
        if (hold_q) thr_q <= thr_load ? thr_in : AW'(THR_DEF);
    end

    // Pointer and flag registers, all updated from the post-write count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            in_ready    <= 1'b0;
            half_full   <= 1'b0;
            almost_flag <= 1'b1;
        end else begin
            wbin        <= wbin_nx;
            wgray       <= wbin_nx ^ (wbin_nx >> 1);
            in_ready    <= (used_nx != DEPTH);
            half_full   <= (used_nx >= HALF_MARK);
            almost_flag <= (used_nx <= {1'b0, thr_q}) || (used_nx >= hi_mark);
        end
    end
endmodule

// File: rtl/fifo_rd_ctrl.sv
`timescale 1ns/1ps
// fifo_rd_ctrl: read pointer and fall-through output register in the
// read-clock domain. Assumes wgray_s is the synchronized write pointer;
// an entry is only loaded once its write is visible, so out_ready never
// claims a word that is not stored.
module fifo_rd_ctrl #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_req,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          out_ready
);
    logic [AW:0] rbin, rbin_nx;
    logic        empty, take, load;

    assign empty   = (rgray == wgray_s);
    assign take    = take_req & out_ready;
    assign load    = !empty && (!out_ready || take);
    assign rbin_nx = rbin + {{AW{1'b0}}, load};
    assign raddr   = rbin[AW-1:0];

    // Refill the output register when empty or being consumed; else hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            rd_data   <= '0;
            out_ready <= 1'b0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            if (load) begin
                rd_data   <= mem_q;
                out_ready <= 1'b1;
            end else if (take) begin
                out_ready <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_clk_ft_fifo.sv
`timescale 1ns/1ps
// dual_clk_ft_fifo: top of the dual-clock fall-through FIFO. Releases the
// reset separately into each clock, crosses Gray pointers both ways and
// decodes the write and read enable groups. Assumes rst_n is held across
// at least four edges of each clock.
module dual_clk_ft_fifo #(
    parameter int DW      = fifo_pkg::DEF_DW,
    parameter int AW      = fifo_pkg::DEF_AW,
    parameter int THR_DEF = fifo_pkg::DEF_THR
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          thr_load,
    input  logic [AW-1:0] thr_in,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en_hi,
    input  logic          wr_en_lo_n,
    output logic          in_ready,
    input  logic          rd_en_n,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          half_full,
    output logic          almost_flag
);
    logic          wr_rst_n, rd_rst_n;
    logic [AW:0]   w_gray, r_gray, w_gray_rs, r_gray_ws;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_q;
    logic          push;

    // Per-domain reset release.
    fifo_sync #(.W(1)) u_wr_rst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n));
    fifo_sync #(.W(1)) u_rd_rst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n));

    // Gray pointer crossings.
    fifo_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(r_gray), .q(r_gray_ws));
    fifo_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(w_gray), .q(w_gray_rs));

    fifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    fifo_wr_ctrl #(.AW(AW), .THR_DEF(THR_DEF)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_req(wr_en_hi & ~wr_en_lo_n),
        .rgray_s(r_gray_ws), .thr_load(thr_load), .thr_in(thr_in),
        .push(push), .waddr(waddr), .wgray(w_gray), .in_ready(in_ready),
        .half_full(half_full), .almost_flag(almost_flag)
    );

    fifo_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .take_req(~(rd_en_n | oe_a_n | oe_b_n)),
        .wgray_s(w_gray_rs), .mem_q(mem_q), .raddr(raddr), .rgray(r_gray),
        .rd_data(rd_data), .out_ready(out_ready)
    );
endmodule

// File: rtl/fifo_checker.sv
`timescale 1ns/1ps
// fifo_checker: temporal properties of dual_clk_ft_fifo, bound to the top.
module fifo_checker #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wr_rst_n,
    input logic          rd_rst_n,
    input logic          wr_en_hi,
    input logic          wr_en_lo_n,
    input logic          in_ready,
    input logic          half_full,
    input logic          almost_flag,
    input logic [AW:0]   w_gray,
    input logic          rd_en_n,
    input logic          oe_a_n,
    input logic          oe_b_n,
    input logic          out_ready,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   r_gray,
    input logic [AW:0]   w_gray_rs
);
    // Write-side flag values while the side is in reset (R6).
    always @(negedge wr_clk) begin
        if (!wr_rst_n) begin
            assert_wr_reset_flags_R6: assert (!in_ready && !half_full && almost_flag);
        end
    end

    // Read-side flag value while the side is in reset (R6).
    always @(negedge rd_clk) begin
        if (!rd_rst_n) begin
            assert_rd_reset_flags_R6: assert (!out_ready);
        end
    end

    // No write may be committed while input-ready is low (R5).
    assert_full_blocks_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !in_ready |=> $stable(w_gray));

    // Wrong enable polarity commits nothing (R2).
    assert_wr_polarity_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !(wr_en_hi && !wr_en_lo_n) |=> $stable(w_gray));

    // Without all three read enables low the output word is held (R3).
    assert_hold_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (out_ready && (rd_en_n || oe_a_n || oe_b_n)) |=> (out_ready && $stable(rd_data)));

    // out_ready only drops after a consuming edge (R10).
    assert_ready_drop_R10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(out_ready) |-> $past(!rd_en_n && !oe_a_n && !oe_b_n));

    // A visible stored word falls through into an empty output register (R4).
    assert_fall_through_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!out_ready && (r_gray != w_gray_rs)) |=> out_ready);
endmodule

bind dual_clk_ft_fifo fifo_checker #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
    .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n), .in_ready(in_ready),
    .half_full(half_full), .almost_flag(almost_flag), .w_gray(w_gray),
    .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .out_ready(out_ready),
    .rd_data(rd_data), .r_gray(r_gray), .w_gray_rs(w_gray_rs)
);

// File: tb/tb_dual_clk_ft_fifo.sv
`timescale 1ns/1ps
module tb_dual_clk_ft_fifo;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        rst_n, thr_load;
    logic [5:0]  thr_in;
    logic [17:0] wr_data;
    logic        wr_en_hi, wr_en_lo_n, in_ready;
    logic        rd_en_n, oe_a_n, oe_b_n, out_ready, half_full, almost_flag;
    logic [17:0] rd_data;

    logic [17:0] sb[$];
    int n_chk = 0, n_fail = 0;
    bit wdone;

    always #5   wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    dual_clk_ft_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .thr_load(thr_load),
        .thr_in(thr_in), .wr_data(wr_data), .wr_en_hi(wr_en_hi),
        .wr_en_lo_n(wr_en_lo_n), .in_ready(in_ready), .rd_en_n(rd_en_n),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .rd_data(rd_data),
        .out_ready(out_ready), .half_full(half_full), .almost_flag(almost_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare the word being consumed with the scoreboard head (R1).
    always begin
        @(negedge rd_clk);
        #1;
        if (rst_n && out_ready && !rd_en_n && !oe_a_n && !oe_b_n) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "read with empty scoreboard", {14'd0, rd_data}, 32'd0);
            end else begin
                logic [17:0] exp_w;
                exp_w = sb.pop_front();
                check(rd_data == exp_w, "R1", "order", {14'd0, rd_data}, {14'd0, exp_w});
            end
        end
    end

    // Driver: one write attempt; scoreboard gets the word only if accepted.
    task automatic push_word(input logic [17:0] d, output bit ok);
        @(negedge wr_clk);
        wr_data = d; wr_en_hi = 1'b1; wr_en_lo_n = 1'b0;
        ok = in_ready;
        @(posedge wr_clk);
        if (ok) sb.push_back(d);
        @(negedge wr_clk);
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
    endtask

    task automatic do_reset(input bit ld, input logic [5:0] t);
        @(negedge wr_clk);
        rst_n = 1'b0; thr_load = ld; thr_in = t;
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1;
        rd_en_n = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
        check(!in_ready && !out_ready, "R6", "ready flags in reset", {in_ready, out_ready}, 0);
        check(!half_full && almost_flag, "R6", "level flags in reset", {half_full, almost_flag}, 1);
        sb.delete();
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (6) @(negedge wr_clk);
        thr_load = 1'b0; thr_in = 6'd0;
    endtask

    task automatic drain(input string req);
        @(negedge rd_clk);
        rd_en_n = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b0;
        while (sb.size() != 0) @(negedge rd_clk);
        repeat (6) @(negedge rd_clk);
        check(!out_ready, req, "out_ready after last word", {31'd0, out_ready}, 0);
    endtask

    // Fill with reads stopped, checking level flags after every attempt.
    task automatic fill_check(input int thr);
        bit ok;
        int acc, mc;
        @(negedge rd_clk); rd_en_n = 1'b1;
        push_word(18'h100, ok);
        acc = ok ? 1 : 0;
        repeat (10) @(negedge wr_clk);
        check(!half_full && almost_flag, "R8", "flags with empty storage", {half_full, almost_flag}, 1);
        for (int i = 1; i < 70; i++) begin
            push_word(18'h100 + 18'(i), ok);
            if (ok) acc++;
            mc = acc - 1;
            check(half_full == (mc >= 33), "R7", $sformatf("half_full at %0d", mc),
                  {31'd0, half_full}, {31'd0, (mc >= 33)});
            check(almost_flag == (mc <= thr || mc >= 64 - thr), thr == 8 ? "R8" : "R9",
                  $sformatf("almost at %0d", mc), {31'd0, almost_flag},
                  {31'd0, (mc <= thr || mc >= 64 - thr)});
        end
        check(acc == 65, "R5", "words accepted before full", acc, 65);
        check(!in_ready, "R5", "in_ready when full", {31'd0, in_ready}, 0);
        drain("R10");
    endtask

    initial begin
        bit ok;
        rst_n = 1'b1; thr_load = 1'b0; thr_in = '0; wr_data = '0;
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1; rd_en_n = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
        #1 rst_n = 1'b0;

        // Reset values, polarity, fall-through and enable gating.
        do_reset(1'b0, 6'd0);
        @(negedge wr_clk);
        wr_data = 18'h3ABCD; wr_en_hi = 1'b1; wr_en_lo_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        wr_en_lo_n = 1'b1;
        repeat (10) @(negedge rd_clk);
        check(!out_ready, "R2", "no write with wrong polarity", {31'd0, out_ready}, 0);

        push_word(18'h1A5A5, ok);
        repeat (10) @(negedge rd_clk);
        check(out_ready, "R4", "fall-through out_ready", {31'd0, out_ready}, 1);
        check(rd_data == 18'h1A5A5, "R4", "fall-through data", {14'd0, rd_data}, 32'h1A5A5);
        push_word(18'h05A5A, ok);
        @(negedge rd_clk); rd_en_n = 1'b0; oe_a_n = 1'b1;
        repeat (8) @(negedge rd_clk);
        check(out_ready && rd_data == 18'h1A5A5, "R3", "hold with oe_a_n high",
              {14'd0, rd_data}, 32'h1A5A5);
        oe_a_n = 1'b0; oe_b_n = 1'b1;
        repeat (8) @(negedge rd_clk);
        check(out_ready && rd_data == 18'h1A5A5, "R3", "hold with oe_b_n high",
              {14'd0, rd_data}, 32'h1A5A5);
        drain("R10");

        // Fill and flags with the default threshold.
        fill_check(8);

        // Random traffic with reads throttled.
        wdone = 1'b0;
        fork
            begin
                int n = 0;
                while (n < 400) begin
                    repeat ($urandom % 3) @(negedge wr_clk);
                    push_word(18'($urandom), ok);
                    if (ok) n++;
                end
                wdone = 1'b1;
            end
            begin
                while (!wdone) begin
                    @(negedge rd_clk);
                    rd_en_n = ($urandom % 4 == 0);
                end
            end
        join
        drain("R1");

        // Programmed threshold.
        do_reset(1'b1, 6'd3);
        fill_check(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule